// File: doc/BRIEF.md
# Three-Order Ping-Pong Reorder Buffer

This block sits between a contiguous input stream and three consumers that each need the same three-dimensional data in a different traversal order. One element is a cube of N x N x N items. The items arrive once, on a single valid/ready stream, with the i coordinate changing fastest, then j, then k. Each accepted item is written into three replicated on-chip buffers, one per consumer. The external source is therefore read only once, and each consumer gets its own copy to walk in its own order.

Every replicated buffer holds two banks. While one element is being filled into one bank, the readers drain the previous element from the other bank, so filling and draining overlap. Each reader has its own bank pointer and its own nested address counter, so a consumer that stalls holds back only its own stream. A bank is reused for filling only after all three readers have finished with it. Each output item carries the index of the element it belongs to.

Top module: `tri_order_reorder`

## Requirements
- R1: During reset and on the first cycle after it, `in_ready` is 1 and all three `out_valid` bits are 0. Both banks are empty and all counters are zero.
- R2: An input item is taken on every cycle where `in_valid` and `in_ready` are both high. The n-th item of an element (n from 0) has coordinates i = n mod N, j = (n / N) mod N and k = n / N².
- R3: Output 0 presents the items of each element with i changing fastest, then j, then k.
- R4: Output 1 presents the items of each element with j changing fastest, then k, then i.
- R5: Output 2 presents the items of each element with k changing fastest, then i, then j.
- R6: Each output presents every item of every element exactly once, element after element. `out_tag` equals the element's position since reset (the first element is 0), modulo 2^TAG_W.
- R7: At most two elements are held. `in_ready` stays low while the bank due for filling still holds an element that any one of the three outputs has not fully presented.
- R8: No output presents an item of an element before the last item of that element has been accepted.
- R9: A stalled output (its `out_ready` held low) does not stop the other outputs from presenting their items.
- R10: While `out_valid` is high and `out_ready` is low, that output's valid, data and tag hold their values on the next cycle.
- R11: With `in_valid` held high and every `out_ready` high, the input accepts one item per cycle and each output presents one item per cycle, including across element boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_data | input | DATA_W | Input item payload |
| out_valid | output | 3 | Per output: item present |
| out_ready | input | 3 | Per output: consumer takes the item |
| out_data | output | 3 x DATA_W | Per output: item payload |
| out_tag | output | 3 x TAG_W | Per output: element index of the item |

## Verification
The checker watches, on every cycle, the reset state, the holding of each output under back-pressure, the tag moving forward by at most one from item to item, and an occupancy bound. That bound is the number of items accepted but not yet presented, for each output, and it never exceeds two elements. The three traversal orders, the exact element boundaries, the gating of the input by the slowest reader, and the independence of a running reader from stalled ones all depend on a sequence of stimulus. Only the bench scenarios can show them, and the bench compares every presented item against a scoreboard. The one-item-per-cycle rate is shown by timing a back-to-back run of two elements at the ports.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int NUM_RD = 3;

    // traversal order, named fastest coordinate first
    typedef enum logic [1:0] {
        WALK_IJK = 2'd0,
        WALK_JKI = 2'd1,
        WALK_KIJ = 2'd2
    } walk_e;

    // end-of-element notice from a reader to the fill controller
    typedef struct packed {
        logic done;
        logic bank;
    } rd_evt_t;

    // storage address {k,j,i} for a reader whose counter digits are
    // a (fastest), b, c (slowest)
    function automatic int walk_addr(walk_e w, int a, int b, int c, int logn);
        int i;
        int j;
        int k;
        case (w)
            WALK_JKI: begin j = a; k = b; i = c; end
            WALK_KIJ: begin k = a; i = b; j = c; end
            default:  begin i = a; j = b; k = c; end
        endcase
        return (k << (2 * logn)) | (j << logn) | i;
    endfunction

endpackage

// File: rtl/rob_bank_mem.sv
module rob_bank_mem #(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/rob_fill_ctrl.sv
module rob_fill_ctrl
    import rob_pkg::*;
#(
    parameter int LOG_N = 3,
    parameter int TAG_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    output logic                          in_ready,
    output logic                          wr_en,
    output logic [3*LOG_N:0]              wr_addr,
    input  rd_evt_t [NUM_RD-1:0]          rd_evt,
    output logic [1:0][NUM_RD-1:0]        pend,
    output logic [1:0][TAG_W-1:0]         bank_tag
);
    localparam int CW = 3 * LOG_N;

    logic [CW-1:0]    wcnt;
    logic             wbank;
    logic [TAG_W-1:0] elem_tag;
    logic             last_item;

    assign in_ready  = ~|pend[wbank];
    assign wr_en     = in_valid & in_ready;
    assign wr_addr   = {wbank, wcnt};
    assign last_item = &wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt     <= '0;
            wbank    <= 1'b0;
            elem_tag <= '0;
            pend     <= '0;
            bank_tag <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                for (int r = 0; r < NUM_RD; r++) begin
                    if (rd_evt[r].done && (rd_evt[r].bank == 1'(b)))
                        pend[b][r] <= 1'b0;
                end
            end
            if (wr_en) begin
                wcnt <= wcnt + 1'b1;
                if (last_item) begin
                    wbank           <= ~wbank;
                    pend[wbank]     <= '1;
                    bank_tag[wbank] <= elem_tag;
                    elem_tag        <= elem_tag + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rob_reader.sv
module rob_reader
    import rob_pkg::*;
#(
    parameter int    LOG_N  = 3,
    parameter int    TAG_W  = 8,
    parameter int    DATA_W = 16,
    parameter walk_e WALK   = WALK_IJK
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               pend_mine,
    input  logic [1:0][TAG_W-1:0]    bank_tag,
    output logic                     re,
    output logic [3*LOG_N:0]         raddr,
    input  logic [DATA_W-1:0]        rdata,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DATA_W-1:0]        out_data,
    output logic [TAG_W-1:0]         out_tag,
    output rd_evt_t                  evt
);
    localparam int CW = 3 * LOG_N;

    logic [CW-1:0] rcnt;
    logic          rbank;
    logic          issue;
    logic [CW-1:0] walk_a;

    always_comb begin
        walk_a = CW'(walk_addr(WALK,
                               int'(rcnt[LOG_N-1:0]),
                               int'(rcnt[2*LOG_N-1:LOG_N]),
                               int'(rcnt[CW-1:2*LOG_N]),
                               LOG_N));
    end

    // fetch only when the output slot is empty or emptying this cycle
    assign issue    = pend_mine[rbank] & (~out_valid | out_ready);
    assign re       = issue;
    assign raddr    = {rbank, walk_a};
    assign out_data = rdata;
    assign evt.done = issue & (&rcnt);
    assign evt.bank = rbank;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt      <= '0;
            rbank     <= 1'b0;
            out_valid <= 1'b0;
            out_tag   <= '0;
        end else begin
            out_valid <= issue | (out_valid & ~out_ready);
            if (issue) begin
                rcnt    <= rcnt + 1'b1;
                out_tag <= bank_tag[rbank];
                if (&rcnt) rbank <= ~rbank;
            end
        end
    end

endmodule

// File: rtl/tri_order_reorder.sv
module tri_order_reorder
    import rob_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOG_N  = 3,
    parameter int TAG_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [DATA_W-1:0]              in_data,
    output logic [NUM_RD-1:0]              out_valid,
    input  logic [NUM_RD-1:0]              out_ready,
    output logic [NUM_RD-1:0][DATA_W-1:0]  out_data,
    output logic [NUM_RD-1:0][TAG_W-1:0]   out_tag
);
    localparam int AW = 3 * LOG_N + 1;

    logic                          wr_en;
    logic [AW-1:0]                 wr_addr;
    rd_evt_t [NUM_RD-1:0]          evts;
    logic [1:0][NUM_RD-1:0]        pend;
    logic [1:0][TAG_W-1:0]         bank_tag;

    rob_fill_ctrl #(.LOG_N(LOG_N), .TAG_W(TAG_W)) u_fill (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_evt   (evts),
        .pend     (pend),
        .bank_tag (bank_tag)
    );

    for (genvar g = 0; g < NUM_RD; g++) begin : g_lane
        logic              re;
        logic [AW-1:0]     raddr;
        logic [DATA_W-1:0] rdata;
        logic [1:0]        pend_mine;

        assign pend_mine = {pend[1][g], pend[0][g]};

        rob_bank_mem #(.DW(DATA_W), .AW(AW)) u_mem (
            .clk   (clk),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (in_data),
            .re    (re),
            .raddr (raddr),
            .rdata (rdata)
        );

        rob_reader #(
            .LOG_N (LOG_N),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W),
            .WALK  (walk_e'(g))
        ) u_rd (
            .clk       (clk),
            .rst       (rst),
            .pend_mine (pend_mine),
            .bank_tag  (bank_tag),
            .re        (re),
            .raddr     (raddr),
            .rdata     (rdata),
            .out_valid (out_valid[g]),
            .out_ready (out_ready[g]),
            .out_data  (out_data[g]),
            .out_tag   (out_tag[g]),
            .evt       (evts[g])
        );
    end

endmodule

// File: rtl/rob_chk.sv
module rob_chk
    import rob_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOG_N  = 3,
    parameter int TAG_W  = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           in_valid,
    input logic                           in_ready,
    input logic [NUM_RD-1:0]              out_valid,
    input logic [NUM_RD-1:0]              out_ready,
    input logic [NUM_RD-1:0][DATA_W-1:0]  out_data,
    input logic [NUM_RD-1:0][TAG_W-1:0]   out_tag
);
    localparam int ITEMS = 1 << (3 * LOG_N);
    localparam int OW    = 3 * LOG_N + 3;

    logic [OW-1:0] occ [NUM_RD];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_RD; r++) occ[r] <= '0;
        end else begin
            for (int r = 0; r < NUM_RD; r++)
                occ[r] <= occ[r] + OW'(in_valid && in_ready)
                                 - OW'(out_valid[r] && out_ready[r]);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (out_valid == '0) && in_ready);

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        // R10
        hold_out_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[r] && !out_ready[r] |=>
                out_valid[r] && $stable(out_data[r]) && $stable(out_tag[r]));

        // R6
        tag_step_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[r] && $past(out_valid[r] && out_ready[r]) |->
                (out_tag[r] == $past(out_tag[r])) ||
                (out_tag[r] == TAG_W'($past(out_tag[r]) + 1'b1)));

        // R7
        no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
            occ[r] <= OW'(2 * ITEMS));
    end

endmodule

bind tri_order_reorder rob_chk #(
    .DATA_W(DATA_W),
    .LOG_N (LOG_N),
    .TAG_W (TAG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_tag   (out_tag)
);

// File: tb/sim_tri_order_reorder.sv
module sim_tri_order_reorder;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int LOG_N  = 3;
    localparam int TAG_W  = 8;
    localparam int N      = 1 << LOG_N;
    localparam int ITEMS  = N * N * N;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic                          in_valid = 1'b0;
    logic                          in_ready;
    logic [DATA_W-1:0]             in_data = '0;
    logic [NUM_RD-1:0]             out_valid;
    logic [NUM_RD-1:0]             out_ready = '0;
    logic [NUM_RD-1:0][DATA_W-1:0] out_data;
    logic [NUM_RD-1:0][TAG_W-1:0]  out_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tri_order_reorder #(.DATA_W(DATA_W), .LOG_N(LOG_N), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_tag(out_tag)
    );

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    int accepted = 0;
    int pops [NUM_RD];
    int rdy_mode [NUM_RD];   // 0 stall, 1 ready, 2 random
    bit gaps = 0;
    logic [TAG_W+DATA_W-1:0] expq0 [$];
    logic [TAG_W+DATA_W-1:0] expq1 [$];
    logic [TAG_W+DATA_W-1:0] expq2 [$];
    int t_first0 = -1;
    int t_last0  = -1;
    bit prev_stall [NUM_RD];
    logic [DATA_W-1:0] prev_data [NUM_RD];
    logic [TAG_W-1:0]  prev_tag  [NUM_RD];
    bit send_done = 0;
    string ord_req [NUM_RD] = '{"R3", "R4", "R5"};

    function automatic logic [DATA_W-1:0] dval(int e, int idx);
        return DATA_W'(e * 1237 + idx * 7 + 3);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void push_exp(int r, logic [TAG_W+DATA_W-1:0] v);
        case (r)
            0: expq0.push_back(v);
            1: expq1.push_back(v);
            default: expq2.push_back(v);
        endcase
    endfunction

    function automatic int qsize(int r);
        case (r)
            0: return expq0.size();
            1: return expq1.size();
            default: return expq2.size();
        endcase
    endfunction

    function automatic logic [TAG_W+DATA_W-1:0] pop_exp(int r);
        case (r)
            0: return expq0.pop_front();
            1: return expq1.pop_front();
            default: return expq2.pop_front();
        endcase
    endfunction

    // R2: item n of an element has i = n%N, j = (n/N)%N, k = n/N^2
    task automatic send_elem(int e, int stop_before = ITEMS);
        for (int r = 0; r < NUM_RD; r++)
            for (int c = 0; c < N; c++)
                for (int b = 0; b < N; b++)
                    for (int a = 0; a < N; a++) begin
                        int i, j, k;
                        if (r == 0) begin i = a; j = b; k = c; end
                        else if (r == 1) begin j = a; k = b; i = c; end
                        else begin k = a; i = b; j = c; end
                        if (stop_before == ITEMS)
                            push_exp(r, {TAG_W'(e), dval(e, i + N*j + N*N*k)});
                    end
        for (int n = 0; n < stop_before; n++) send_item(dval(e, n));
    endtask

    task automatic push_elem_exp(int e);
        for (int r = 0; r < NUM_RD; r++)
            for (int c = 0; c < N; c++)
                for (int b = 0; b < N; b++)
                    for (int a = 0; a < N; a++) begin
                        int i, j, k;
                        if (r == 0) begin i = a; j = b; k = c; end
                        else if (r == 1) begin j = a; k = b; i = c; end
                        else begin k = a; i = b; j = c; end
                        push_exp(r, {TAG_W'(e), dval(e, i + N*j + N*N*k)});
                    end
    endtask

    task automatic send_item(logic [DATA_W-1:0] d);
        if (gaps) begin
            int g = int'($urandom % 3);
            repeat (g) begin @(posedge clk); #1; end
        end
        in_valid = 1'b1;
        in_data  = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (qsize(0) != 0 || qsize(1) != 0 || qsize(2) != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        for (int r = 0; r < NUM_RD; r++)
            out_ready[r] = (rdy_mode[r] == 1) ||
                           (rdy_mode[r] == 2 && ($urandom % 2 == 0));
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        ncyc++;
        if (!rst) begin
            if (in_valid && in_ready) accepted++;
            for (int r = 0; r < NUM_RD; r++) begin
                if (prev_stall[r]) begin
                    check(out_valid[r] && out_data[r] == prev_data[r] &&
                          out_tag[r] == prev_tag[r], "R10", "held output",
                          int'(out_data[r]), int'(prev_data[r]));
                end
                if (out_valid[r] && out_ready[r]) begin
                    pops[r]++;
                    if (qsize(r) == 0) begin
                        check(1'b0, "R6", "unexpected item", int'(out_data[r]), 0);
                    end else begin
                        logic [TAG_W+DATA_W-1:0] ex;
                        ex = pop_exp(r);
                        check(out_data[r] == ex[DATA_W-1:0], ord_req[r],
                              "order data", int'(out_data[r]), int'(ex[DATA_W-1:0]));
                        check(out_tag[r] == ex[TAG_W+DATA_W-1:DATA_W], "R6",
                              "element tag", int'(out_tag[r]),
                              int'(ex[TAG_W+DATA_W-1:DATA_W]));
                        if (r == 0 && out_tag[r] == TAG_W'(1) && t_first0 < 0)
                            t_first0 = ncyc;
                        if (r == 0 && out_tag[r] == TAG_W'(2)) t_last0 = ncyc;
                    end
                end
                prev_stall[r] = out_valid[r] && !out_ready[r];
                prev_data[r]  = out_data[r];
                prev_tag[r]   = out_tag[r];
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R6", "watchdog expired", ncyc, 0);
        finish_run();
    end

    initial begin
        int t0, a0;
        int p [NUM_RD];
        for (int r = 0; r < NUM_RD; r++) begin
            pops[r] = 0; rdy_mode[r] = 1; prev_stall[r] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R8: element 0 held back until its last item
        @(posedge clk); #1;
        push_elem_exp(0);
        for (int n = 0; n < ITEMS - 1; n++) send_item(dval(0, n));
        repeat (5) @(posedge clk); #1;
        @(negedge clk);
        check(out_valid == '0, "R8", "no output before last item",
              int'(out_valid), 0);
        check(accepted == ITEMS - 1, "R2", "items accepted", accepted, ITEMS - 1);
        @(posedge clk); #1;
        send_item(dval(0, ITEMS - 1));
        repeat (2) @(negedge clk);
        check(out_valid == 3'b111, "R8", "output after last item",
              int'(out_valid), 7);
        drain();

        // R11: two back-to-back elements at full rate
        @(posedge clk); #1;
        t0 = ncyc;
        send_elem(1);
        send_elem(2);
        check(ncyc - t0 == 2 * ITEMS, "R11", "input cycles", ncyc - t0, 2 * ITEMS);
        drain();
        check(t_last0 - t_first0 == 2 * ITEMS - 1, "R11", "output cycles",
              t_last0 - t_first0, 2 * ITEMS - 1);

        // R9 / R7: outputs 1 and 2 stalled
        rdy_mode[1] = 0; rdy_mode[2] = 0;
        for (int r = 0; r < NUM_RD; r++) p[r] = pops[r];
        a0 = accepted;
        @(posedge clk); #1;
        send_elem(3);
        send_elem(4);
        send_done = 0;
        fork
            begin send_elem(5); send_done = 1; end
        join_none
        repeat (600) @(negedge clk);
        check(pops[0] - p[0] == 2 * ITEMS, "R9", "free output progress",
              pops[0] - p[0], 2 * ITEMS);
        check(pops[1] - p[1] == 0, "R9", "stalled output 1", pops[1] - p[1], 0);
        check(pops[2] - p[2] == 0, "R9", "stalled output 2", pops[2] - p[2], 0);
        check(accepted - a0 == 2 * ITEMS, "R7", "two elements held",
              accepted - a0, 2 * ITEMS);
        check(in_ready == 1'b0, "R7", "input blocked", int'(in_ready), 0);
        rdy_mode[1] = 1;
        repeat (1100) @(negedge clk);
        check(pops[1] - p[1] == 2 * ITEMS, "R9", "output 1 after release",
              pops[1] - p[1], 2 * ITEMS);
        check(accepted - a0 == 2 * ITEMS, "R7", "blocked by last reader",
              accepted - a0, 2 * ITEMS);
        check(in_ready == 1'b0, "R7", "input still blocked", int'(in_ready), 0);
        rdy_mode[2] = 1;
        while (!send_done) @(negedge clk);
        drain();
        check(accepted - a0 == 3 * ITEMS, "R7", "third element taken",
              accepted - a0, 3 * ITEMS);

        // random back-pressure and input gaps
        for (int r = 0; r < NUM_RD; r++) rdy_mode[r] = 2;
        gaps = 1;
        @(posedge clk); #1;
        for (int e = 6; e < 10; e++) send_elem(e);
        drain();
        for (int r = 0; r < NUM_RD; r++)
            check(pops[r] == 10 * ITEMS, "R6", "items per output",
                  pops[r], 10 * ITEMS);
        finish_run();
    end

endmodule